// File: doc/BRIEF.md
# Operand Bypass Unit with Register File

This block supplies the two ALU operands of a five-stage in-order pipeline. It holds the eight-entry, 16-bit register file, with two combinational read ports used by decode and one write port driven by write-back. It also resolves read-after-write hazards for the instruction in execute. Each source register number of that instruction is compared against the destinations waiting in the execute/memory and memory/writeback pipeline registers. The matching result is then steered onto the operand, in place of the value that was read from the register file in decode.

Dependences are covered by distance from the producer. At distance one, the result is taken from the execute/memory register. At distance two, it is taken from the memory/writeback register. At distance three, the register file passes the write-back data straight to a read at the same address in the same cycle. At distance four or more, the value is already stored. With all four cases covered, a chain of dependent ALU instructions needs no stall. Stall generation for loads, branch handling and the ALU itself live elsewhere.

Top module: `operand_bypass`

## Requirements
- R1: After reset every register entry reads as zero on both read ports.
- R2: When `wb_we` is 1 at a rising clock edge, entry `wb_rd` takes `wb_val`; a later read of that entry returns it.
- R3: While `wb_we` is 1 and a read address equals `wb_rd`, that read port returns `wb_val` in the same cycle, combinationally.
- R4: If `mem_we` is 1 and `mem_rd` equals an execute source number, that operand's select is 2'b10 and the operand equals `mem_val`.
- R5: If the operand has no execute/memory match, `wb_we` is 1 and `wb_rd` equals its source number, the select is 2'b01 and the operand equals `wb_val`.
- R6: When both stages match the same source, the execute/memory result (select 2'b10) wins.
- R7: A stage whose write enable is 0 never forwards. With no match, the select is 2'b00 and the operand equals the value latched from decode (`ex_rf_a` / `ex_rf_b`).
- R8: The two operands are resolved independently; each may pick a different source in the same cycle.
- R9: In an add followed by four instructions that each read its destination, every reader sees the new sum in execute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the register file |
| rd_addr_a | input | 3 | Decode read address, port A |
| rd_addr_b | input | 3 | Decode read address, port B |
| rd_data_a | output | 16 | Read data, port A (with write bypass) |
| rd_data_b | output | 16 | Read data, port B (with write bypass) |
| ex_rs1 | input | 3 | First source register number of the execute instruction |
| ex_rs2 | input | 3 | Second source register number of the execute instruction |
| ex_rf_a | input | 16 | First operand as read in decode |
| ex_rf_b | input | 16 | Second operand as read in decode |
| mem_we | input | 1 | Execute/memory stage will write a register |
| mem_rd | input | 3 | Execute/memory destination number |
| mem_val | input | 16 | Execute/memory result |
| wb_we | input | 1 | Write-back enable (register file write port) |
| wb_rd | input | 3 | Write-back destination number |
| wb_val | input | 16 | Write-back data |
| sel_a | output | 2 | Operand A source: 00 file, 01 writeback, 10 execute/memory |
| sel_b | output | 2 | Operand B source, same encoding |
| op_a | output | 16 | Resolved ALU operand A |
| op_b | output | 16 | Resolved ALU operand B |

## Verification
The selects, the operands and the bypassed read data are combinational. They are due in the same cycle as their inputs. A register write becomes visible one edge later. The bench drives inputs just after the falling edge, compares against its reference model 1 ns later, before the next rising edge, and updates its model of the stored entries only at that rising edge. In the dependent-chain scenario the bench moves the instructions through decode, execute, memory and write-back itself. Each reader is checked in the cycle it occupies execute, which falls one to four cycles after the add.

// File: rtl/operand_bypass.sv
module operand_bypass #(
  parameter int NREGS = 8,
  parameter int WIDTH = 16,
  localparam int AW = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    rd_addr_a,
  input  logic [AW-1:0]    rd_addr_b,
  output logic [WIDTH-1:0] rd_data_a,
  output logic [WIDTH-1:0] rd_data_b,
  input  logic [AW-1:0]    ex_rs1,
  input  logic [AW-1:0]    ex_rs2,
  input  logic [WIDTH-1:0] ex_rf_a,
  input  logic [WIDTH-1:0] ex_rf_b,
  input  logic             mem_we,
  input  logic [AW-1:0]    mem_rd,
  input  logic [WIDTH-1:0] mem_val,
  input  logic             wb_we,
  input  logic [AW-1:0]    wb_rd,
  input  logic [WIDTH-1:0] wb_val,
  output logic [1:0]       sel_a,
  output logic [1:0]       sel_b,
  output logic [WIDTH-1:0] op_a,
  output logic [WIDTH-1:0] op_b
);

  logic [WIDTH-1:0] regs [NREGS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (wb_we) begin
      regs[wb_rd] <= wb_val;
    end
  end

  assign rd_data_a = (wb_we && wb_rd == rd_addr_a) ? wb_val : regs[rd_addr_a];
  assign rd_data_b = (wb_we && wb_rd == rd_addr_b) ? wb_val : regs[rd_addr_b];

  function automatic logic [1:0] pick(input logic [AW-1:0] src);
    if (mem_we && mem_rd == src)     return 2'b10;
    else if (wb_we && wb_rd == src)  return 2'b01;
    else                             return 2'b00;
  endfunction

  function automatic logic [WIDTH-1:0] route(input logic [1:0] s, input logic [WIDTH-1:0] rf);
    case (s)
      2'b10:   return mem_val;
      2'b01:   return wb_val;
      default: return rf;
    endcase
  endfunction

  assign sel_a = pick(ex_rs1);
  assign sel_b = pick(ex_rs2);
  assign op_a  = route(sel_a, ex_rf_a);
  assign op_b  = route(sel_b, ex_rf_b);

  assert_stored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wb_we) && rd_addr_a == $past(wb_rd) && !(wb_we && wb_rd == rd_addr_a))
      |-> rd_data_a == $past(wb_val));

  assert_same_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_we && wb_rd == rd_addr_b) |-> rd_data_b == wb_val);

  assert_exmem_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_rd == ex_rs1) |-> (op_a == mem_val && sel_a == 2'b10));

  assert_memwb_fwd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_we && wb_rd == ex_rs2 && !(mem_we && mem_rd == ex_rs2)) |-> (op_b == wb_val && sel_b == 2'b01));

  assert_no_fwd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!(mem_we && mem_rd == ex_rs1) && !(wb_we && wb_rd == ex_rs1)) |-> (op_a == ex_rf_a && sel_a == 2'b00));

endmodule

// File: tb/test_operand_bypass.sv
module test_operand_bypass;
  logic clk = 0, rst_n = 0;
  logic [2:0] rd_addr_a = 0, rd_addr_b = 0, ex_rs1 = 0, ex_rs2 = 0, mem_rd = 0, wb_rd = 0;
  logic [15:0] ex_rf_a = 0, ex_rf_b = 0, mem_val = 0, wb_val = 0;
  logic mem_we = 0, wb_we = 0;
  logic [15:0] rd_data_a, rd_data_b, op_a, op_b;
  logic [1:0] sel_a, sel_b;
  int checks = 0, fails = 0;
  logic [15:0] model [8];

  always #2 clk = ~clk;

  operand_bypass i_operand_bypass (.*);

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] exp_sel(input logic [2:0] s);
    if (mem_we && mem_rd == s) return 2'b10;
    if (wb_we && wb_rd == s) return 2'b01;
    return 2'b00;
  endfunction

  task automatic edge_update();
    @(posedge clk);
    if (rst_n && wb_we) model[wb_rd] = wb_val;
    @(negedge clk);
  endtask

  // full reference comparison of all outputs for the current inputs
  task automatic compare_all();
    logic [1:0] ea, eb;
    logic [15:0] va, vb, da, db;
    #1;
    ea = exp_sel(ex_rs1); eb = exp_sel(ex_rs2);
    va = ea == 2'b10 ? mem_val : ea == 2'b01 ? wb_val : ex_rf_a;
    vb = eb == 2'b10 ? mem_val : eb == 2'b01 ? wb_val : ex_rf_b;
    da = (wb_we && wb_rd == rd_addr_a) ? wb_val : model[rd_addr_a];
    db = (wb_we && wb_rd == rd_addr_b) ? wb_val : model[rd_addr_b];
    chk(sel_a == ea, (ea == 2'b10 && wb_we && wb_rd == ex_rs1) ? "R6 sel_a" : "R4/R5/R7 sel_a", 16'(sel_a), 16'(ea));
    chk(sel_b == eb, "R8 sel_b", 16'(sel_b), 16'(eb));
    chk(op_a == va, "R4/R5/R7 op_a", op_a, va);
    chk(op_b == vb, "R8 op_b", op_b, vb);
    chk(rd_data_a == da, (wb_we && wb_rd == rd_addr_a) ? "R3 rd_data_a" : "R2 rd_data_a", rd_data_a, da);
    chk(rd_data_b == db, "R2/R3 rd_data_b", rd_data_b, db);
  endtask

  // dependent chain program
  logic [2:0] p_rd [8], p_s1 [8], p_s2 [8];
  logic       p_we [8];
  logic [15:0] p_res [8], p_a [8], p_b [8];

  initial begin
    #1000000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset contents
    for (int i = 0; i < 8; i++) begin
      rd_addr_a = 3'(i); rd_addr_b = 3'(7 - i);
      #1;
      chk(rd_data_a == 0, "R1 port A after reset", rd_data_a, 16'h0);
      chk(rd_data_b == 0, "R1 port B after reset", rd_data_b, 16'h0);
      @(negedge clk);
    end
    // directed: R6 both stages match, R7 enables low
    ex_rs1 = 3; ex_rs2 = 3; ex_rf_a = 16'h1111; ex_rf_b = 16'h2222;
    mem_we = 1; mem_rd = 3; mem_val = 16'hAAAA; wb_we = 1; wb_rd = 3; wb_val = 16'h5555;
    #1;
    chk(sel_a == 2'b10 && op_a == 16'hAAAA, "R6 newest producer wins", op_a, 16'hAAAA);
    edge_update();
    mem_we = 0; wb_we = 0;
    #1;
    chk(sel_a == 2'b00 && op_a == 16'h1111, "R7 disabled stages ignored", op_a, 16'h1111);
    chk(rd_data_a == model[rd_addr_a], "R2 stored write", rd_data_a, model[rd_addr_a]);
    @(negedge clk);
    // preload for chain
    for (int i = 0; i < 8; i++) begin
      wb_we = 1; wb_rd = 3'(i); wb_val = 16'(100 + 7 * i);
      edge_update();
    end
    wb_we = 0;
    // R9: r1 = r2 + r3, then four readers of r1
    p_rd[0] = 1; p_s1[0] = 2; p_s2[0] = 3;
    for (int k = 1; k < 5; k++) begin p_rd[k] = 3'(3 + k); p_s1[k] = 1; p_s2[k] = 3'(k - 1); end
    for (int k = 0; k < 5; k++) p_we[k] = 1;
    begin
      logic [15:0] g [8];
      for (int i = 0; i < 8; i++) g[i] = model[i];
      for (int k = 0; k < 5; k++) begin
        p_a[k] = g[p_s1[k]]; p_b[k] = g[p_s2[k]];
        p_res[k] = p_a[k] + p_b[k];
        g[p_rd[k]] = p_res[k];
      end
    end
    begin
      logic [15:0] la, lb;
      la = 0; lb = 0;
      for (int c = 0; c < 9; c++) begin
        int id, ex, mm, wb;
        id = c; ex = c - 1; mm = c - 2; wb = c - 3;
        rd_addr_a = (id < 5) ? p_s1[id] : 3'd0;
        rd_addr_b = (id < 5) ? p_s2[id] : 3'd0;
        ex_rs1 = (ex >= 0 && ex < 5) ? p_s1[ex] : 3'd0;
        ex_rs2 = (ex >= 0 && ex < 5) ? p_s2[ex] : 3'd0;
        ex_rf_a = la; ex_rf_b = lb;
        mem_we = (mm >= 0 && mm < 5); mem_rd = mem_we ? p_rd[mm] : 3'd0; mem_val = mem_we ? p_res[mm] : 16'h0;
        wb_we = (wb >= 0 && wb < 5); wb_rd = wb_we ? p_rd[wb] : 3'd0; wb_val = wb_we ? p_res[wb] : 16'h0;
        #1;
        if (ex >= 0 && ex < 5) begin
          chk(op_a == p_a[ex], $sformatf("R9 chain instr %0d operand A", ex), op_a, p_a[ex]);
          chk(op_b == p_b[ex], $sformatf("R9 chain instr %0d operand B", ex), op_b, p_b[ex]);
        end
        la = rd_data_a; lb = rd_data_b;
        edge_update();
      end
    end
    // randomized cycles against the reference model
    for (int n = 0; n < 400; n++) begin
      rd_addr_a = 3'($urandom); rd_addr_b = 3'($urandom);
      ex_rs1 = 3'($urandom); ex_rs2 = 3'($urandom);
      ex_rf_a = 16'($urandom); ex_rf_b = 16'($urandom);
      mem_we = 1'($urandom); mem_rd = 3'($urandom); mem_val = 16'($urandom);
      wb_we = 1'($urandom); wb_rd = 3'($urandom); wb_val = 16'($urandom);
      if (n % 5 == 0) begin mem_rd = ex_rs1; wb_rd = ex_rs1; end
      if (n % 7 == 0) wb_rd = rd_addr_a;
      compare_all();
      edge_update();
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule